// File: doc/BRIEF.md
# Processor Clock Divider with Reset and Ready Synchronizer

This block produces the processor clock by dividing one of two source clocks by three. The result is high for one source period and low for two. The source is a crystal-derived clock or an external frequency input, picked by a select pin.

Alongside the clock, the block re-times two control requests to the generated clock:

- **Reset.** An asynchronous active-low reset request becomes a processor reset. That reset moves only on falling edges of the generated clock, and once raised it stays high for a minimum number of generated cycles.
- **Ready.** Two active-low wait-state requests from slow devices are combined into one ready signal. It passes through two re-timing stages: the first samples on the generated rising edge and the second updates on the falling edge. This way ready is settled well before the next rising edge, where a new T3 state would begin.

No data flows through the block, so it has no valid/ready stream interface. Every pin is a plain clock, control or status level.

Top module: `cg_clkgen`

## Requirements
- R1: `cpu_clk` has a period of `DIV_RATIO` (default 3) source-clock cycles and is high for `HIGH_PHASES` (default 1) of them, so by default it runs at one third of the source frequency with a one-third high time.
- R2: With `src_ext` = 0 the divider runs from `clk_xtal`; with `src_ext` = 1 it runs from `clk_ext`. The select may only be changed while a reset is requested.
- R3: `cpu_rst` changes only on a source edge where `cpu_clk` falls. It goes high within `DIV_RATIO` + 1 source cycles of `rst_req_n` going low.
- R4: `cpu_rst` stays high for as long as `rst_req_n` is held low.
- R5: Once high, `cpu_rst` stays high for at least `MIN_RST_CYC` (default 4) generated clock cycles, even for a request far shorter than one cycle. After the request is released it falls within `MIN_RST_CYC` + 3 generated cycles.
- R6: `cpu_rdy` goes low within two generated cycles when any bit of `rdy_req_n` is held low. It returns high within two generated cycles once all bits are high again.
- R7: `cpu_rdy` changes only on a source edge where `cpu_clk` falls.
- R8: Before the first source edge, `cpu_rst`, `cpu_rdy` and `cpu_clk` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal-derived source clock |
| clk_ext | input | 1 | External frequency source clock |
| src_ext | input | 1 | Source select: 1 = `clk_ext`, 0 = `clk_xtal` |
| rst_req_n | input | 1 | Asynchronous reset request, active low |
| rdy_req_n | input | N_RDY | Wait-state requests, active low, one per device group |
| cpu_clk | output | 1 | Generated processor clock |
| cpu_rst | output | 1 | Processor reset, active high, re-timed to `cpu_clk` falling edges |
| cpu_rdy | output | 1 | Processor ready, active high, re-timed to `cpu_clk` falling edges |

## Verification
The bench builds the block with its defaults: divide by three, one high phase, a four-cycle reset minimum and two ready inputs. With these values a single request pulse shorter than one source period is enough to exercise the whole stretch counter. The setting also makes it possible to count the exact low-high pattern after a source switch between clocks of unrelated periods. Each ready input is driven on its own and both are driven together, so the AND of the requests and its two-edge re-timing are both observed.

// File: rtl/cg_pkg.sv
package cg_pkg;
  // Default geometry shared by the divider, the synchronizers and the checker
  localparam int unsigned CG_DIV_DEF  = 3;
  localparam int unsigned CG_HIGH_DEF = 1;
  localparam int unsigned CG_MINR_DEF = 4;
  localparam int unsigned CG_NRDY_DEF = 2;

  // Saturating step for small monitor counters
  function automatic logic [7:0] cg_sat_inc(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction
endpackage

// File: rtl/cg_divider.sv
module cg_divider #(
  parameter int unsigned DIV  = cg_pkg::CG_DIV_DEF,
  parameter int unsigned HIGH = cg_pkg::CG_HIGH_DEF
) (
  input  logic clk_src,
  output logic cpu_clk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;

  // phase 0..HIGH-1 is the high part of the generated clock
  logic [PW-1:0] ph = '0;
  logic [PW-1:0] ph_nxt;
  logic          clk_q = 1'b1;

  always_comb begin
    ph_nxt = (ph == PW'(DIV - 1)) ? '0 : ph + PW'(1);
  end

  always_ff @(posedge clk_src) begin
    ph    <= ph_nxt;
    clk_q <= (ph_nxt < PW'(HIGH));
  end

  assign cpu_clk   = clk_q;
  // source edge on which cpu_clk rises / falls
  assign rise_tick = (ph == PW'(DIV - 1));
  assign fall_tick = (ph == PW'(HIGH - 1));
endmodule

// File: rtl/cg_rst_sync.sv
module cg_rst_sync #(
  parameter int unsigned MIN_CYC = cg_pkg::CG_MINR_DEF
) (
  input  logic clk_src,
  input  logic fall_tick,
  input  logic req_n,
  output logic rst_out
);
  localparam int unsigned HW = $clog2(MIN_CYC + 1);

  // two stages, set at once by the request, cleared one per falling tick
  logic          sync_a = 1'b1;
  logic          sync_b = 1'b1;
  logic [HW-1:0] hold   = HW'(MIN_CYC - 1);
  logic          rst_q  = 1'b1;

  always_ff @(posedge clk_src or negedge req_n) begin
    if (!req_n) begin
      sync_a <= 1'b1;
      sync_b <= 1'b1;
    end else if (fall_tick) begin
      sync_a <= 1'b0;
      sync_b <= sync_a;
    end
  end

  // output moves only on falling ticks; hold stretches the high time
  always_ff @(posedge clk_src) begin
    if (fall_tick) begin
      if (sync_b) begin
        hold  <= HW'(MIN_CYC - 1);
        rst_q <= 1'b1;
      end else begin
        rst_q <= (hold != '0);
        if (hold != '0) hold <= hold - HW'(1);
      end
    end
  end

  assign rst_out = rst_q;
endmodule

// File: rtl/cg_rdy_sync.sv
module cg_rdy_sync #(
  parameter int unsigned N = cg_pkg::CG_NRDY_DEF
) (
  input  logic         clk_src,
  input  logic         rise_tick,
  input  logic         fall_tick,
  input  logic [N-1:0] req_n,
  output logic         rdy_out
);
  logic stage_rise = 1'b1;
  logic stage_fall = 1'b1;

  // first stage on the generated rising edge, second on the falling edge
  always_ff @(posedge clk_src) begin
    if (rise_tick) stage_rise <= &req_n;
    if (fall_tick) stage_fall <= stage_rise;
  end

  assign rdy_out = stage_fall;
endmodule

// File: rtl/cg_clkgen.sv
module cg_clkgen #(
  parameter int unsigned DIV_RATIO   = cg_pkg::CG_DIV_DEF,
  parameter int unsigned HIGH_PHASES = cg_pkg::CG_HIGH_DEF,
  parameter int unsigned MIN_RST_CYC = cg_pkg::CG_MINR_DEF,
  parameter int unsigned N_RDY       = cg_pkg::CG_NRDY_DEF
) (
  input  logic             clk_xtal,
  input  logic             clk_ext,
  input  logic             src_ext,
  input  logic             rst_req_n,
  input  logic [N_RDY-1:0] rdy_req_n,
  output logic             cpu_clk,
  output logic             cpu_rst,
  output logic             cpu_rdy
);
  logic clk_src;
  logic rise_tick;
  logic fall_tick;

  // source select; only switched while reset is requested
  assign clk_src = src_ext ? clk_ext : clk_xtal;

  cg_divider #(.DIV(DIV_RATIO), .HIGH(HIGH_PHASES)) u_div (
    .clk_src  (clk_src),
    .cpu_clk  (cpu_clk),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick)
  );

  cg_rst_sync #(.MIN_CYC(MIN_RST_CYC)) u_rst (
    .clk_src  (clk_src),
    .fall_tick(fall_tick),
    .req_n    (rst_req_n),
    .rst_out  (cpu_rst)
  );

  cg_rdy_sync #(.N(N_RDY)) u_rdy (
    .clk_src  (clk_src),
    .rise_tick(rise_tick),
    .fall_tick(fall_tick),
    .req_n    (rdy_req_n),
    .rdy_out  (cpu_rdy)
  );
endmodule

// File: rtl/cg_clkgen_chk.sv
module cg_clkgen_chk #(
  parameter int unsigned DIV   = cg_pkg::CG_DIV_DEF,
  parameter int unsigned HIGH  = cg_pkg::CG_HIGH_DEF,
  parameter int unsigned MINR  = cg_pkg::CG_MINR_DEF,
  parameter int unsigned NRDY  = cg_pkg::CG_NRDY_DEF
) (
  input logic            clk_src,
  input logic            rst_req_n,
  input logic [NRDY-1:0] rdy_req_n,
  input logic            cpu_clk,
  input logic            cpu_rst,
  input logic            cpu_rdy
);
  import cg_pkg::*;

  logic [2:0] warm_cnt = '0;
  logic       warm;
  logic [7:0] lo_run   = '0;
  logic [7:0] hi_run   = '0;
  logic [7:0] rst_falls = '0;
  logic [7:0] req_low  = '0;
  logic [7:0] wait_low = '0;
  logic [7:0] wait_hi  = '0;

  assign warm = (warm_cnt == 3'd4);

  always_ff @(posedge clk_src) begin
    if (!warm) warm_cnt <= warm_cnt + 3'd1;
    lo_run    <= cpu_clk ? 8'd0 : cg_sat_inc(lo_run);
    hi_run    <= cpu_clk ? cg_sat_inc(hi_run) : 8'd0;
    rst_falls <= !cpu_rst ? 8'd0 :
                 (warm && $fell(cpu_clk)) ? cg_sat_inc(rst_falls) : rst_falls;
    req_low   <= rst_req_n ? 8'd0 : cg_sat_inc(req_low);
    wait_low  <= (&rdy_req_n) ? 8'd0 : cg_sat_inc(wait_low);
    wait_hi   <= (&rdy_req_n) ? cg_sat_inc(wait_hi) : 8'd0;
  end

  // R1: low run and high run lengths of the generated clock
  a_r1_low_run: assert property (@(posedge clk_src) disable iff (!warm)
    $rose(cpu_clk) |-> (lo_run == 8'(DIV - HIGH)));
  a_r1_high_run: assert property (@(posedge clk_src) disable iff (!warm)
    $fell(cpu_clk) |-> (hi_run == 8'(HIGH)));

  // R3: reset moves only with a falling generated edge
  a_r3_rst_on_fall: assert property (@(posedge clk_src) disable iff (!warm)
    !$stable(cpu_rst) |-> $fell(cpu_clk));

  // R4: a held request keeps reset high
  a_r4_rst_held: assert property (@(posedge clk_src) disable iff (!warm)
    (req_low >= 8'(DIV + 1)) |-> cpu_rst);

  // R5: minimum high time of reset
  a_r5_min_width: assert property (@(posedge clk_src) disable iff (!warm)
    $fell(cpu_rst) |-> (rst_falls >= 8'(MINR)));

  // R6: ready follows the combined requests
  a_r6_rdy_low: assert property (@(posedge clk_src) disable iff (!warm)
    (wait_low >= 8'(2 * DIV + 1)) |-> !cpu_rdy);
  a_r6_rdy_high: assert property (@(posedge clk_src) disable iff (!warm)
    (wait_hi >= 8'(2 * DIV + 1)) |-> cpu_rdy);

  // R7: ready moves only with a falling generated edge
  a_r7_rdy_on_fall: assert property (@(posedge clk_src) disable iff (!warm)
    !$stable(cpu_rdy) |-> $fell(cpu_clk));
endmodule

bind cg_clkgen cg_clkgen_chk #(
  .DIV (DIV_RATIO),
  .HIGH(HIGH_PHASES),
  .MINR(MIN_RST_CYC),
  .NRDY(N_RDY)
) u_chk (
  .clk_src  (clk_src),
  .rst_req_n(rst_req_n),
  .rdy_req_n(rdy_req_n),
  .cpu_clk  (cpu_clk),
  .cpu_rst  (cpu_rst),
  .cpu_rdy  (cpu_rdy)
);

// File: tb/cg_clkgen_bench.sv
module cg_clkgen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int EXT_PERIOD = 16;
  localparam int DIV  = 3;
  localparam int HIGH = 1;
  localparam int MINR = 4;

  logic       clk_xtal = 1'b0;
  logic       clk_ext  = 1'b0;
  logic       src_ext  = 1'b0;
  logic       rst_req_n = 1'b0;
  logic [1:0] rdy_req_n = 2'b11;
  logic       cpu_clk, cpu_rst, cpu_rdy;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  mon_on = 1'b0;
  bit  done   = 1'b0;
  logic p_clk, p_rst, p_rdy;

  always #(CLK_PERIOD / 2) clk_xtal = ~clk_xtal;
  always #(EXT_PERIOD / 2) clk_ext  = ~clk_ext;

  cg_clkgen u_cg_clkgen (
    .clk_xtal (clk_xtal),
    .clk_ext  (clk_ext),
    .src_ext  (src_ext),
    .rst_req_n(rst_req_n),
    .rdy_req_n(rdy_req_n),
    .cpu_clk  (cpu_clk),
    .cpu_rst  (cpu_rst),
    .cpu_rdy  (cpu_rdy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance one source cycle, sample away from the active edge, watch alignment
  task automatic step();
    if (src_ext) @(negedge clk_ext); else @(negedge clk_xtal);
    if (mon_on) begin
      if (cpu_rst !== p_rst)
        check(p_clk && !cpu_clk, "R3 reset change off falling edge", int'(cpu_clk), 0);
      if (cpu_rdy !== p_rdy)
        check(p_clk && !cpu_clk, "R7 ready change off falling edge", int'(cpu_clk), 0);
    end
    p_clk = cpu_clk; p_rst = cpu_rst; p_rdy = cpu_rdy;
  endtask

  task automatic t_power_up();
    #1;
    check(cpu_rst === 1'b1, "R8 reset at power-up", int'(cpu_rst), 1);
    check(cpu_rdy === 1'b1, "R8 ready at power-up", int'(cpu_rdy), 1);
    check(cpu_clk === 1'b1, "R8 clock at power-up", int'(cpu_clk), 1);
    p_clk = cpu_clk; p_rst = cpu_rst; p_rdy = cpu_rdy;
    mon_on = 1'b1;
  endtask

  task automatic t_divide(input string req);
    logic prev;
    int   mism = 0;
    for (int i = 0; i < 10; i++) begin
      prev = cpu_clk;
      step();
      if (prev && !cpu_clk) break;
    end
    for (int k = 1; k <= 4 * DIV; k++) begin
      step();
      if (cpu_clk !== ((k % DIV) >= (DIV - HIGH))) mism++;
    end
    check(mism == 0, req, mism, 0);
  endtask

  task automatic t_reset_held();
    bit stayed = 1'b1;
    for (int i = 0; i < 30; i++) begin
      step();
      if (cpu_rst !== 1'b1) stayed = 1'b0;
    end
    check(stayed, "R4 reset held while requested", int'(stayed), 1);
  endtask

  task automatic t_reset_release();
    int n = 0;
    rst_req_n = 1'b1;
    while (cpu_rst === 1'b1 && n < 60) begin step(); n++; end
    check(n >= MINR * DIV && n <= (MINR + 3) * DIV, "R5 release latency", n, (MINR + 2) * DIV);
  endtask

  task automatic t_reset_assert();
    int n = 0;
    for (int i = 0; i < 7; i++) step();
    rst_req_n = 1'b0;
    while (cpu_rst !== 1'b1 && n < 20) begin step(); n++; end
    check(n >= 1 && n <= DIV + 1, "R3 assert latency", n, DIV);
    t_reset_held();
  endtask

  task automatic t_short_pulse();
    int hi = 0;
    int n  = 0;
    for (int i = 0; i < 5; i++) step();
    check(cpu_rst === 1'b0, "R5 idle before pulse", int'(cpu_rst), 0);
    rst_req_n = 1'b0;
    #1 rst_req_n = 1'b1;
    while (cpu_rst !== 1'b1 && n < 20) begin step(); n++; end
    check(cpu_rst === 1'b1, "R3 short pulse seen", int'(cpu_rst), 1);
    while (cpu_rst === 1'b1 && hi < 60) begin step(); hi++; end
    check(hi >= MINR * DIV && hi < 60, "R5 minimum reset width", hi, MINR * DIV);
  endtask

  task automatic t_ready_one(input int bitn);
    int  n = 0;
    bit  stayed = 1'b1;
    rdy_req_n = 2'b11;
    rdy_req_n[bitn] = 1'b0;
    while (cpu_rdy !== 1'b0 && n < 20) begin step(); n++; end
    check(n <= 2 * DIV, "R6 ready drop latency", n, 2 * DIV);
    for (int i = 0; i < 12; i++) begin
      step();
      if (cpu_rdy !== 1'b0) stayed = 1'b0;
    end
    check(stayed, "R6 ready stays low", int'(stayed), 1);
    rdy_req_n = 2'b11;
    n = 0;
    while (cpu_rdy !== 1'b1 && n < 20) begin step(); n++; end
    check(n <= 2 * DIV, "R6 ready rise latency", n, 2 * DIV);
  endtask

  task automatic t_ready_both();
    int n = 0;
    rdy_req_n = 2'b00;
    for (int i = 0; i < 8; i++) step();
    rdy_req_n = 2'b01;
    for (int i = 0; i < 9; i++) step();
    check(cpu_rdy === 1'b0, "R6 one request still pending", int'(cpu_rdy), 0);
    rdy_req_n = 2'b11;
    while (cpu_rdy !== 1'b1 && n < 20) begin step(); n++; end
    check(cpu_rdy === 1'b1, "R6 ready after both released", int'(cpu_rdy), 1);
  endtask

  task automatic t_source_ext();
    rst_req_n = 1'b0;
    for (int i = 0; i < 6; i++) step();
    mon_on = 1'b0;
    src_ext = 1'b1;
    step();
    step();
    mon_on = 1'b1;
    t_divide("R2 divide from external source");
    t_reset_held();
    t_reset_release();
    t_ready_one(0);
  endtask

  initial begin
    t_power_up();
    t_divide("R1 divide from crystal source");
    t_reset_held();
    t_reset_release();
    t_divide("R1 divide after reset release");
    t_reset_assert();
    t_reset_release();
    t_short_pulse();
    t_ready_one(0);
    t_ready_one(1);
    t_ready_both();
    t_source_ext();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_xtal);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule